// File: doc/BRIEF.md
# Fixed-Priority Interrupt Resolver with Mixed Pin Sensitivity

This block collects the interrupt requests of a small signal processor and reduces them to a single request index for the program sequencer. It serves a reset request and eleven prioritized sources. Seven are active-low pins: one reset-request pin, two pins that are always level-sensitive, one that is always edge-sensitive, and three whose sensitivity is chosen at run time. The rest are one-cycle internal pulses from a timer, a byte DMA engine, the transmit and receive sides of two serial ports, and the power-down circuit. Software can also raise any latched source through a per-source set pulse.

Every pin passes through a synchronizer. A falling edge on an edge-sensitive pin sets a pending latch, and so does an internal pulse. A level-sensitive pin requests only while it is held low. Each pending source is then gated by its own enable bit and by a global enable, and the lowest-numbered surviving request is presented as the output index. Reset and power-down ignore both kinds of gating. The sequencer acknowledges a source by index, and that clears only that source's latch. The second serial port's two slots can be handed over to two of the programmable pins.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with all pins high, `irq_valid_o` is 0 and `irq_idx_o` is 0.
- R2: Pins `irql1_n_i` (index 3) and `irql0_n_i` (index 4) request only while held low. The request disappears once the pin returns high, and nothing is latched.
- R3: A falling edge on `irqe_n_i` latches index 7. The request remains after the pin returns high, until it is acknowledged.
- R4: `edge_irq2_i`, `edge_irq1_i` and `edge_irq0_i` = 1 make `irq2_n_i` (index 2), `irq1_n_i` (index 9) and `irq0_n_i` (index 10) edge-latched. When the bit is 0, that pin is level-sensitive.
- R5: A latched request whose enable is off stays latched, and appears as soon as the enable is turned back on.
- R6: Index 0 has the highest priority and index 11 the lowest. The indices are: 0 reset request, 1 power-down, 2 irq2, 3 irql1, 4 irql0, 5 serial-0 transmit, 6 serial-0 receive, 7 irqe, 8 byte DMA, 9 serial-1 transmit or irq1, 10 serial-1 receive or irq0, 11 timer. The output is the lowest enabled pending index.
- R7: `mask_i[j]` = 1 enables source j+2. Sources 0 and 1 have no enable bit.
- R8: With `glob_en_i` = 0, only indices 0 and 1 can be output.
- R9: A low `rst_req_n_i` yields index 0 regardless of enables and other requests.
- R10: One cycle with `ack_i` = 1 clears the latch selected by `ack_idx_i` and no other. If a new set arrives in the same cycle, the set wins.
- R11: With `ser1_pin_mode_i` = 0, indices 9 and 10 come from `ser1_tx_p_i` and `ser1_rx_p_i`, and `irq1_n_i`/`irq0_n_i` are ignored. With 1, the pins drive these indices and the pulses are ignored.
- R12: `sw_set_i[k]` latches source k when k is currently latched-type. For level-type indices (0, 3, 4, and any programmable source in level mode) it has no effect.
- R13: Latency, counted in rising clock edges: a low level shows after 2, a falling edge after 3, and an internal or software pulse after 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| rst_req_n_i | input | 1 | Reset-request pin, active low, level |
| irq2_n_i | input | 1 | Programmable pin, index 2 |
| irql0_n_i | input | 1 | Level pin, index 4 |
| irql1_n_i | input | 1 | Level pin, index 3 |
| irqe_n_i | input | 1 | Edge pin, index 7 |
| irq0_n_i | input | 1 | Programmable pin, index 10 in pin mode |
| irq1_n_i | input | 1 | Programmable pin, index 9 in pin mode |
| edge_irq2_i | input | 1 | 1 = irq2 edge-sensitive |
| edge_irq0_i | input | 1 | 1 = irq0 edge-sensitive |
| edge_irq1_i | input | 1 | 1 = irq1 edge-sensitive |
| ser1_pin_mode_i | input | 1 | 1 = slots 9/10 from pins |
| pwrdn_p_i | input | 1 | Power-down pulse |
| timer_p_i | input | 1 | Timer pulse |
| bdma_p_i | input | 1 | Byte DMA pulse |
| ser0_tx_p_i | input | 1 | Serial-0 transmit pulse |
| ser0_rx_p_i | input | 1 | Serial-0 receive pulse |
| ser1_tx_p_i | input | 1 | Serial-1 transmit pulse |
| ser1_rx_p_i | input | 1 | Serial-1 receive pulse |
| sw_set_i | input | 12 | Software set pulse per index |
| glob_en_i | input | 1 | Global enable for indices 2..11 |
| mask_i | input | 10 | Bit j enables index j+2 |
| ack_i | input | 1 | Acknowledge strobe |
| ack_idx_i | input | 4 | Index to acknowledge |
| irq_valid_o | output | 1 | A request is being presented |
| irq_idx_o | output | 4 | Winning index |

## Verification
The bench goes after the exact latency of each input path. A design with one synchronizer stage too many, or too few, would present its request a cycle late or early. It checks that an edge latch survives masking, the global enable and the pin's return high, since a design that cleared or recomputed the latch would lose the interrupt. It also checks that an acknowledge clears only the named source: a decoder fault would show up as a second pending source vanishing. Finally, it checks that stimulus the current mode should ignore, such as serial-1 pulses in pin mode or software sets on level sources, raises nothing. A design that routed these wrongly would show a spurious index.

// File: rtl/irq_prio_pkg.sv
// Shared constants for the interrupt resolver: source indices in priority
// order (0 = highest) and positions of the synchronized pins.
package irq_prio_pkg;
    localparam int NSRC  = 12;
    localparam int IDX_W = $clog2(NSRC);
    localparam int NMASK = NSRC - 2;
    localparam int NPIN  = 7;

    // source indices; the numeric order is the priority order
    localparam int S_RST    = 0;
    localparam int S_PWRDN  = 1;
    localparam int S_IRQ2   = 2;
    localparam int S_IRQL1  = 3;
    localparam int S_IRQL0  = 4;
    localparam int S_SER0TX = 5;
    localparam int S_SER0RX = 6;
    localparam int S_IRQE   = 7;
    localparam int S_BDMA   = 8;
    localparam int S_SER1TX = 9;
    localparam int S_SER1RX = 10;
    localparam int S_TIMER  = 11;

    // bit positions in the synchronizer vector
    localparam int P_RST   = 0;
    localparam int P_IRQ2  = 1;
    localparam int P_IRQL1 = 2;
    localparam int P_IRQL0 = 3;
    localparam int P_IRQE  = 4;
    localparam int P_IRQ1  = 5;
    localparam int P_IRQ0  = 6;

    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_pin_sync.sv
// Synchronizes W active-low pins through STAGES flops. Outputs the active
// level (1 = pin low) and a one-cycle falling-edge event.
// Assumes STAGES >= 2; flops reset to the idle (high) pin level.
module irq_pin_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_n_i,
    output logic [W-1:0] low_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] hist_q;

    // shift chain plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '1;
            hist_q <= '1;
        end else begin
            stg_q[0] <= pin_n_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
            hist_q <= stg_q[STAGES-1];
        end
    end

    assign low_o  = ~stg_q[STAGES-1];
    assign fall_o = hist_q & ~stg_q[STAGES-1];
endmodule

// File: rtl/irq_pend_bank.sv
// Bank of N pending latches. A set pulse wins over a clear pulse in the
// same cycle, so no event is lost. Assumes set/clear are synchronous.
module irq_pend_bank #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    for (genvar k = 0; k < N; k++) begin : g_bit
        logic bit_q;
        // one pending latch: set dominates clear
        always_ff @(posedge clk) begin
            if (!rst_n)          bit_q <= 1'b0;
            else if (set_i[k])   bit_q <= 1'b1;
            else if (clr_i[k])   bit_q <= 1'b0;
        end
        assign pend_o[k] = bit_q;
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority picker: returns the lowest set index of req_i.
// Purely combinational; assumes IW can hold N-1.
module irq_prio_pick #(
    parameter int N  = 12,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req_i,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);
    // scan from lowest priority upward so the lowest index is kept last
    always_comb begin
        valid_o = |req_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Interrupt resolver top. Synchronizes the pins, forms latch-set and level
// vectors per source mode, gates with per-source and global enables (reset
// and power-down ungated) and picks the highest-priority request.
// Assumes internal pulses and ack are synchronous to clk.
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_req_n_i,
    input  logic             irq2_n_i,
    input  logic             irql0_n_i,
    input  logic             irql1_n_i,
    input  logic             irqe_n_i,
    input  logic             irq0_n_i,
    input  logic             irq1_n_i,
    input  logic             edge_irq2_i,
    input  logic             edge_irq0_i,
    input  logic             edge_irq1_i,
    input  logic             ser1_pin_mode_i,
    input  logic             pwrdn_p_i,
    input  logic             timer_p_i,
    input  logic             bdma_p_i,
    input  logic             ser0_tx_p_i,
    input  logic             ser0_rx_p_i,
    input  logic             ser1_tx_p_i,
    input  logic             ser1_rx_p_i,
    input  logic [NSRC-1:0]  sw_set_i,
    input  logic             glob_en_i,
    input  logic [NMASK-1:0] mask_i,
    input  logic             ack_i,
    input  logic [IDX_W-1:0] ack_idx_i,
    output logic             irq_valid_o,
    output logic [IDX_W-1:0] irq_idx_o
);
    logic [NPIN-1:0] pin_n, pin_low, pin_fall;
    src_vec_t pend_set, pend_clr, pend_q;
    src_vec_t lvl_req, latch_type, pending, allow, req;
    logic irq1_edge_mode, irq0_edge_mode;

    // gather pins into the synchronizer vector
    always_comb begin
        pin_n          = '1;
        pin_n[P_RST]   = rst_req_n_i;
        pin_n[P_IRQ2]  = irq2_n_i;
        pin_n[P_IRQL1] = irql1_n_i;
        pin_n[P_IRQL0] = irql0_n_i;
        pin_n[P_IRQE]  = irqe_n_i;
        pin_n[P_IRQ1]  = irq1_n_i;
        pin_n[P_IRQ0]  = irq0_n_i;
    end

    irq_pin_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n_i (pin_n),
        .low_o   (pin_low),
        .fall_o  (pin_fall)
    );

    assign irq1_edge_mode = ser1_pin_mode_i & edge_irq1_i;
    assign irq0_edge_mode = ser1_pin_mode_i & edge_irq0_i;

    // latch-set sources: edges, internal pulses and software sets per mode
    always_comb begin
        pend_set           = '0;
        pend_set[S_RST]    = sw_set_i[S_RST];
        pend_set[S_PWRDN]  = pwrdn_p_i | sw_set_i[S_PWRDN];
        pend_set[S_IRQ2]   = edge_irq2_i & (pin_fall[P_IRQ2] | sw_set_i[S_IRQ2]);
        pend_set[S_IRQL1]  = sw_set_i[S_IRQL1];
        pend_set[S_IRQL0]  = sw_set_i[S_IRQL0];
        pend_set[S_SER0TX] = ser0_tx_p_i | sw_set_i[S_SER0TX];
        pend_set[S_SER0RX] = ser0_rx_p_i | sw_set_i[S_SER0RX];
        pend_set[S_IRQE]   = pin_fall[P_IRQE] | sw_set_i[S_IRQE];
        pend_set[S_BDMA]   = bdma_p_i | sw_set_i[S_BDMA];
        pend_set[S_SER1TX] = ser1_pin_mode_i
                           ? (edge_irq1_i & (pin_fall[P_IRQ1] | sw_set_i[S_SER1TX]))
                           : (ser1_tx_p_i | sw_set_i[S_SER1TX]);
        pend_set[S_SER1RX] = ser1_pin_mode_i
                           ? (edge_irq0_i & (pin_fall[P_IRQ0] | sw_set_i[S_SER1RX]))
                           : (ser1_rx_p_i | sw_set_i[S_SER1RX]);
        pend_set[S_TIMER]  = timer_p_i | sw_set_i[S_TIMER];
    end

    // acknowledge decoder
    always_comb begin
        for (int k = 0; k < NSRC; k++) pend_clr[k] = ack_i && (ack_idx_i == IDX_W'(k));
    end

    irq_pend_bank #(.N(NSRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (pend_set),
        .clr_i  (pend_clr),
        .pend_o (pend_q)
    );

    // which sources currently take their request from a latch
    always_comb begin
        latch_type           = '1;
        latch_type[S_RST]    = 1'b0;
        latch_type[S_IRQL1]  = 1'b0;
        latch_type[S_IRQL0]  = 1'b0;
        latch_type[S_IRQ2]   = edge_irq2_i;
        latch_type[S_SER1TX] = ~ser1_pin_mode_i | edge_irq1_i;
        latch_type[S_SER1RX] = ~ser1_pin_mode_i | edge_irq0_i;
    end

    // level-sensitive requests straight from the synchronized pins
    always_comb begin
        lvl_req           = '0;
        lvl_req[S_RST]    = pin_low[P_RST];
        lvl_req[S_IRQ2]   = ~edge_irq2_i & pin_low[P_IRQ2];
        lvl_req[S_IRQL1]  = pin_low[P_IRQL1];
        lvl_req[S_IRQL0]  = pin_low[P_IRQL0];
        lvl_req[S_SER1TX] = ser1_pin_mode_i & ~irq1_edge_mode & pin_low[P_IRQ1];
        lvl_req[S_SER1RX] = ser1_pin_mode_i & ~irq0_edge_mode & pin_low[P_IRQ0];
    end

    assign pending = (pend_q & latch_type) | lvl_req;

    // enables: reset and power-down bypass both masks
    assign allow[S_RST]   = 1'b1;
    assign allow[S_PWRDN] = 1'b1;
    for (genvar j = 0; j < NMASK; j++) begin : g_allow
        assign allow[j+2] = mask_i[j] & glob_en_i;
    end

    assign req = pending & allow;

    irq_prio_pick #(.N(NSRC), .IW(IDX_W)) u_pick (
        .req_i   (req),
        .valid_o (irq_valid_o),
        .idx_o   (irq_idx_o)
    );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
// Property checker for irq_prio_ctrl, attached by bind below. Watches the
// ports and the latch bank's set and state vectors.
module irq_prio_ctrl_chk
    import irq_prio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_req_n_i,
    input logic             glob_en_i,
    input logic [NMASK-1:0] mask_i,
    input logic             ack_i,
    input logic [IDX_W-1:0] ack_idx_i,
    input logic             irq_valid_o,
    input logic [IDX_W-1:0] irq_idx_o,
    input logic [NSRC-1:0]  pend_q,
    input logic [NSRC-1:0]  pend_set
);
    logic [2:0] since_rst;
    logic [NSRC-1:0] ack_vec;

    // cycles since reset release, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // independent acknowledge decode for the hold property
    always_comb begin
        ack_vec = '0;
        if (ack_i && ack_idx_i < IDX_W'(NSRC)) ack_vec[ack_idx_i] = 1'b1;
    end

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> (irq_idx_o < IDX_W'(NSRC)));  // R6

    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en_i && irq_valid_o) |-> (irq_idx_o <= IDX_W'(1)));  // R8

    AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && irq_idx_o >= IDX_W'(2) && irq_idx_o < IDX_W'(NSRC))
        |-> mask_i[irq_idx_o - IDX_W'(2)]);  // R7

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_q) & ~$past(ack_vec)) & ~pend_q) == '0));  // R5

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && ack_idx_i < IDX_W'(NSRC) && !pend_set[ack_idx_i])
        |=> !pend_q[$past(ack_idx_i)]);  // R10

    AST_RST_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'(SYNC_STAGES) && !$past(rst_req_n_i, SYNC_STAGES))
        |-> (irq_valid_o && irq_idx_o == '0));  // R9
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_req_n_i (rst_req_n_i),
    .glob_en_i   (glob_en_i),
    .mask_i      (mask_i),
    .ack_i       (ack_i),
    .ack_idx_i   (ack_idx_i),
    .irq_valid_o (irq_valid_o),
    .irq_idx_o   (irq_idx_o),
    .pend_q      (pend_q),
    .pend_set    (pend_set)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n;
    logic rst_req_n, irq2_n, irql0_n, irql1_n, irqe_n, irq0_n, irq1_n;
    logic edge2, edge0, edge1, pin_mode;
    logic pwrdn, timer, bdma, s0tx, s0rx, s1tx, s1rx;
    logic [11:0] sw_set;
    logic glob_en;
    logic [9:0] mask;
    logic ack;
    logic [3:0] ack_idx;
    logic irq_valid;
    logic [3:0] irq_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit lat [12];

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .rst_req_n_i(rst_req_n),
        .irq2_n_i(irq2_n), .irql0_n_i(irql0_n), .irql1_n_i(irql1_n),
        .irqe_n_i(irqe_n), .irq0_n_i(irq0_n), .irq1_n_i(irq1_n),
        .edge_irq2_i(edge2), .edge_irq0_i(edge0), .edge_irq1_i(edge1),
        .ser1_pin_mode_i(pin_mode), .pwrdn_p_i(pwrdn), .timer_p_i(timer),
        .bdma_p_i(bdma), .ser0_tx_p_i(s0tx), .ser0_rx_p_i(s0rx),
        .ser1_tx_p_i(s1tx), .ser1_rx_p_i(s1rx), .sw_set_i(sw_set),
        .glob_en_i(glob_en), .mask_i(mask), .ack_i(ack), .ack_idx_i(ack_idx),
        .irq_valid_o(irq_valid), .irq_idx_o(irq_idx)
    );

    // latched-type per source under the current configuration (R4, R11)
    function automatic bit is_latched(int k);
        case (k)
            0, 3, 4: return 1'b0;
            2:       return edge2;
            9:       return !pin_mode || edge1;
            10:      return !pin_mode || edge0;
            default: return 1'b1;
        endcase
    endfunction

    // level request per source from the pins (R2, R4, R9, R11)
    function automatic bit level_req(int k);
        case (k)
            0:  return !rst_req_n;
            2:  return !edge2 && !irq2_n;
            3:  return !irql1_n;
            4:  return !irql0_n;
            9:  return pin_mode && !edge1 && !irq1_n;
            10: return pin_mode && !edge0 && !irq0_n;
            default: return 1'b0;
        endcase
    endfunction

    // expected {valid, idx} from the bench model (R6, R7, R8)
    function automatic logic [4:0] model_out();
        for (int k = 0; k < 12; k++) begin
            bit p, en;
            p  = (lat[k] && is_latched(k)) || level_req(k);
            en = (k < 2) || (glob_en && mask[k-2]);
            if (p && en) return {1'b1, 4'(k)};
        end
        return 5'd0;
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string rq, logic ev, logic [3:0] ei);
        #1;
        n_chk++;
        if (irq_valid !== ev || (ev && irq_idx !== ei)) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b idx=%0d, expected valid=%0b idx=%0d",
                     rq, irq_valid, irq_idx, ev, ei);
        end
    endtask

    task automatic chk_model(string rq);
        logic [4:0] e;
        e = model_out();
        chk(rq, e[4], e[3:0]);
    endtask

    // drive pins; model latches a falling edge on edge-type pins (R3, R4)
    task automatic drive_pins(logic [6:0] np);
        if (!np[1] && irq2_n && edge2) lat[2] = 1'b1;
        if (!np[4] && irqe_n) lat[7] = 1'b1;
        if (!np[5] && irq1_n && pin_mode && edge1) lat[9] = 1'b1;
        if (!np[6] && irq0_n && pin_mode && edge0) lat[10] = 1'b1;
        rst_req_n = np[0]; irq2_n = np[1]; irql1_n = np[2]; irql0_n = np[3];
        irqe_n = np[4]; irq1_n = np[5]; irq0_n = np[6];
    endtask

    // one-cycle pulses: ip = {s1rx,s1tx,s0rx,s0tx,bdma,timer,pwrdn}
    task automatic pulse(logic [6:0] ip, logic [11:0] sw);
        if (ip[0]) lat[1] = 1'b1;
        if (ip[1]) lat[11] = 1'b1;
        if (ip[2]) lat[8] = 1'b1;
        if (ip[3]) lat[5] = 1'b1;
        if (ip[4]) lat[6] = 1'b1;
        if (ip[5] && !pin_mode) lat[9] = 1'b1;
        if (ip[6] && !pin_mode) lat[10] = 1'b1;
        for (int k = 0; k < 12; k++) if (sw[k] && is_latched(k)) lat[k] = 1'b1;
        {s1rx, s1tx, s0rx, s0tx, bdma, timer, pwrdn} = ip;
        sw_set = sw;
        step(1);
        {s1rx, s1tx, s0rx, s0tx, bdma, timer, pwrdn} = '0;
        sw_set = '0;
    endtask

    task automatic do_ack(logic [3:0] idx);
        ack = 1'b1; ack_idx = idx;
        if (idx < 12) lat[idx] = 1'b0;
        step(1);
        ack = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240607));
        rst_n = 1'b0;
        {rst_req_n, irq2_n, irql0_n, irql1_n, irqe_n, irq0_n, irq1_n} = '1;
        {edge2, edge0, edge1, pin_mode} = '0;
        {pwrdn, timer, bdma, s0tx, s0rx, s1tx, s1rx} = '0;
        sw_set = '0; glob_en = 1'b1; mask = '1; ack = 1'b0; ack_idx = '0;
        step(3);
        chk("R1 in reset", 1'b0, 4'd0);
        rst_n = 1'b1;
        step(1);
        chk("R1 after reset", 1'b0, 4'd0);

        // R13 / R2: level pin latency and release
        drive_pins(7'b111_0111);
        step(1); chk("R13 level after 1 edge", 1'b0, 4'd0);
        step(1); chk("R13 level after 2 edges", 1'b1, 4'd4);
        drive_pins('1);
        step(3); chk("R2 level released, nothing latched", 1'b0, 4'd0);

        // R13 / R3: edge pin latency and persistence
        drive_pins(7'b110_1111);
        step(2); chk("R13 edge after 2 edges", 1'b0, 4'd0);
        step(1); chk("R13 edge after 3 edges", 1'b1, 4'd7);
        drive_pins('1);
        step(4); chk("R3 latch held after pin high", 1'b1, 4'd7);
        do_ack(4'd7);
        chk("R3 cleared by ack", 1'b0, 4'd0);

        // R13: internal pulse latency
        pulse(7'b000_0010, '0);
        chk("R13 pulse after 1 edge", 1'b1, 4'd11);
        do_ack(4'd11);

        // R5 / R7: masked latch kept, shown on unmask
        mask[6] = 1'b0;
        pulse(7'b000_0100, '0);
        step(1); chk("R7 masked bdma hidden", 1'b0, 4'd0);
        mask[6] = 1'b1;
        chk("R5 latch survives mask", 1'b1, 4'd8);
        do_ack(4'd8);

        // R8: global enable; power-down bypasses it
        glob_en = 1'b0;
        pulse(7'b000_0011, '0);
        chk("R8 pwrdn bypasses global", 1'b1, 4'd1);
        do_ack(4'd1);
        chk("R8 timer gated by global", 1'b0, 4'd0);
        glob_en = 1'b1;
        chk("R5 timer latch after global on", 1'b1, 4'd11);
        do_ack(4'd11);

        // R9: reset request beats power-down, ignores enables
        glob_en = 1'b0; mask = '0;
        pulse(7'b000_0001, '0);
        drive_pins(7'b111_1110);
        step(2); chk("R9 reset request wins", 1'b1, 4'd0);
        drive_pins('1);
        step(3); chk("R9 release shows pwrdn", 1'b1, 4'd1);
        do_ack(4'd1);
        glob_en = 1'b1; mask = '1;

        // R12: software set on level source ignored, on latched source taken
        pulse(7'b0, 12'b0000_0001_1001);
        step(1); chk("R12 sw set on level sources ignored", 1'b0, 4'd0);
        pulse(7'b0, 12'b0000_0100_0000);
        chk("R12 sw set latches index 6", 1'b1, 4'd6);

        // R10: ack clears only the named source
        pulse(7'b000_1000, '0);
        chk("R6 index 5 beats 6", 1'b1, 4'd5);
        do_ack(4'd5);
        chk("R10 other latch untouched", 1'b1, 4'd6);
        do_ack(4'd6);
        chk("R10 all cleared", 1'b0, 4'd0);

        // R4: programmable pin in edge then level mode
        edge2 = 1'b1;
        drive_pins(7'b111_1101);
        step(3); drive_pins('1);
        step(3); chk("R4 irq2 edge latched", 1'b1, 4'd2);
        do_ack(4'd2);
        edge2 = 1'b0;
        drive_pins(7'b111_1101);
        step(2); chk("R4 irq2 level low", 1'b1, 4'd2);
        drive_pins('1);
        step(2); chk("R4 irq2 level released", 1'b0, 4'd0);

        // R11: slot sharing between serial port 1 and pins
        pin_mode = 1'b0;
        drive_pins(7'b001_1111);
        step(3); chk("R11 pins ignored in serial mode", 1'b0, 4'd0);
        pulse(7'b010_0000, '0);
        chk("R11 serial tx in serial mode", 1'b1, 4'd9);
        do_ack(4'd9);
        drive_pins('1); step(3);
        pin_mode = 1'b1;
        pulse(7'b100_0000, '0);
        step(1); chk("R11 serial rx ignored in pin mode", 1'b0, 4'd0);
        drive_pins(7'b011_1111);
        step(2); chk("R11 irq0 level in pin mode", 1'b1, 4'd10);
        drive_pins('1); step(3);
        pin_mode = 1'b0;

        // random phase (R6 with R5, R7, R8, R10, R11, R12)
        for (int it = 0; it < 400; it++) begin
            logic [6:0] np, ip;
            logic [11:0] sw;
            mask    = 10'($urandom);
            glob_en = ($urandom % 8) != 0;
            edge2   = $urandom % 2;
            edge0   = $urandom % 2;
            edge1   = $urandom % 2;
            if ($urandom % 4 == 0) pin_mode = $urandom % 2;
            for (int b = 0; b < 7; b++) np[b] = ($urandom % 4) != 0;
            if ($urandom % 16 != 0) np[0] = 1'b1;
            drive_pins(np);
            step(4);
            chk_model("R6 random pins");
            for (int b = 0; b < 7; b++) ip[b] = ($urandom % 6) == 0;
            for (int b = 0; b < 12; b++) sw[b] = ($urandom % 10) == 0;
            pulse(ip, sw);
            chk_model("R6 random pulses");
            if ($urandom % 2 == 0) begin
                do_ack((irq_valid && $urandom % 4 != 0) ? irq_idx : 4'($urandom % 12));
                chk_model("R10 random ack");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule